// File: doc/BRIEF.md
# Memory Controller Fault Register Block

This block is the bus-visible register file of an error-correcting memory controller. It holds nine 32-bit registers at word addresses 0 to 8. They cover the controller enable and mode bits, memory delay settings, fault status, a video slot setting, two captured fault addresses, a diagnostic word and two event counters. Software reaches them through a plain word-access port. The port has a byte address, a write strobe, write data and a registered read-data output.

Fault capture enters through a one-cycle error-report input. A report loads the fault status register and both fault address registers. Depending on the error kind and an enable bit, it also raises a level interrupt. The interrupt stays high until software writes the fault status register.

A build-time parameter selects one of three chip variants, coded 0, 1 and 2. The variant sets the enable register write mask and the enable bits that survive a reset. It also decides whether a 4-byte diagnostic byte window is present.

Top module: `memctl_fault_regs`

## Requirements
- R1: The register index is bits 5:2 of the byte address. Indices 0 to 8 select, in order: enable, delay, fault status, video, fault address 0, fault address 1, diagnostic, event count 0 and event count 1. Read data is registered and shows the addressed register one clock after the address is presented.
- R2: Enable register bits 31:28 always read as the variant code (0, 1 or 2), and bits 27:24 always read as zero.
- R3: An enable register write stores the variant code ORed with the write data masked by 0x00000103 for variant 0, or by 0x00000BFF for variants 1 and 2. Bit 1 of the enable register enables interrupts on correctable errors.
- R4: A delay register write stores the data masked with 0x7FFFFFFF, so bit 31 reads as zero.
- R5: After a synchronous reset, the delay register reads 0x20 and fault address 0 reads 0x07C00000. Fault status, video, fault address 1, diagnostic and both event counters read zero, and the interrupt is low.
- R6: Reset keeps only enable bit 8 for variant 0. For variants 1 and 2 it keeps bits 31:24, bits 9:2 and bit 11. All other enable bits clear. Before any write, the enable register holds just the variant code.
- R7: Bus writes to indices 4 and 5 (fault addresses) have no effect.
- R8: An error report loads fault status from the report's status word, and fault addresses 0 and 1 from the report's address words. Bit 16 (multiple errors) is also set if fault status bit 0 (correctable) or bit 3 (uncorrectable) was already set.
- R9: An error report raises the interrupt if its status has bit 3 set, or if it has bit 0 set while enable bit 1 is set. When a report and a fault status write fall in the same cycle, the report wins and the write is dropped.
- R10: A bus write to the fault status register stores the data and deasserts the interrupt.
- R11: The video, diagnostic and two event count registers store and return all 32 written bits. Event count 0 and event count 1 are separate storage.
- R12: Indices 9 to 15 read as zero, and writes to them change no register.
- R13: In variant 0, a 4-byte diagnostic window takes byte writes, and the 2-bit window address selects the byte. A read returns the addressed byte one clock later. In other variants the window reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address, bits 5:2 are the register index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| err_valid | input | 1 | One-cycle error report strobe |
| err_status | input | 32 | Fault status word of the report |
| err_addr0 | input | 32 | Fault address word 0 of the report |
| err_addr1 | input | 32 | Fault address word 1 of the report |
| irq | output | 1 | Level interrupt |
| dg_addr | input | 2 | Diagnostic window byte select |
| dg_we | input | 1 | Diagnostic window write strobe |
| dg_wdata | input | 8 | Diagnostic window write byte |
| dg_rdata | output | 8 | Registered diagnostic window read byte |

## Verification
The hardest case to reach from the ports is an error report that lands in the same cycle as a software write to the fault status register, while an earlier error is still pending. The bench first loads a correctable report. It then drives a second, uncorrectable report and a clearing bus write on the same clock edge. It expects the multiple-error bit set, the bus write dropped and the interrupt held. Reset retention is reached by filling the enable register with ones and pulsing reset, on a variant 0 and a variant 2 instance side by side.

// File: rtl/mcfr_pkg.sv
package mcfr_pkg;
  localparam int NREG = 9;

  typedef enum logic [3:0] {
    IX_ENABLE = 4'd0, IX_DELAY = 4'd1, IX_FSTAT = 4'd2, IX_VIDEO = 4'd3,
    IX_FADDR0 = 4'd4, IX_FADDR1 = 4'd5, IX_DIAG = 4'd6, IX_EVT0 = 4'd7,
    IX_EVT1 = 4'd8
  } reg_idx_e;

  localparam int FS_CE    = 0;
  localparam int FS_UE    = 3;
  localparam int FS_MULTI = 16;
  localparam int EN_CEIRQ = 1;

  localparam logic [31:0] DELAY_RST   = 32'h0000_0020;
  localparam logic [31:0] DELAY_WMASK = 32'h7FFF_FFFF;
  localparam logic [31:0] FADDR0_RST  = 32'h07C0_0000;

  function automatic logic [31:0] en_wmask(input int variant);
    return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [31:0] en_keep(input int variant);
    return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction
endpackage

// File: rtl/mcfr_decode.sv
module mcfr_decode #(
  parameter int ADDR_W = 6,
  parameter int NREG   = 9,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic [NREG-1:0]   we_vec
);
  logic [1:0] unused_lsb;
  assign unused_lsb = addr[1:0];
  assign idx        = addr[ADDR_W-1:2];
  assign in_range   = (32'(idx) < NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign we_vec[i] = we && (idx == IDX_W'(i));
  end

  always_comb begin
    assert ($onehot0(we_vec)) else $error("assert_one_write_R1");
  end
endmodule

// File: rtl/mcfr_fault.sv
module mcfr_fault
  import mcfr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          err_valid,
  input  logic [DW-1:0] err_status,
  input  logic [DW-1:0] err_addr0,
  input  logic [DW-1:0] err_addr1,
  input  logic          ce_irq_en,
  input  logic          st_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] far0_q,
  output logic [DW-1:0] far1_q,
  output logic          irq_q
);
  logic pending, raise;
  assign pending = status_q[FS_CE] | status_q[FS_UE];
  assign raise   = err_status[FS_UE] | (err_status[FS_CE] & ce_irq_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      far0_q   <= DW'(FADDR0_RST);
      far1_q   <= '0;
      irq_q    <= 1'b0;
    end else if (err_valid) begin
      status_q <= err_status | (DW'(pending) << FS_MULTI);
      far0_q   <= err_addr0;
      far1_q   <= err_addr1;
      if (raise) irq_q <= 1'b1;
    end else if (st_we) begin
      status_q <= wdata;
      irq_q    <= 1'b0;
    end
  end

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    st_we && !err_valid |=> !irq_q);
  assert_ue_raises_R9: assert property (@(posedge clk) disable iff (rst)
    err_valid && err_status[FS_UE] |=> irq_q);
  assert_multi_flag_R8: assert property (@(posedge clk) disable iff (rst)
    err_valid && (status_q[FS_CE] || status_q[FS_UE]) |=> status_q[FS_MULTI]);
endmodule

// File: rtl/mcfr_diag.sv
module mcfr_diag #(
  parameter bit PRESENT = 1'b1,
  parameter int BYTES   = 4,
  localparam int AW     = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  if (PRESENT) begin : g_win
    logic [7:0] mem [BYTES];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rd_q <= mem[addr];
    end
    assign rdata = rd_q;
  end else begin : g_none
    logic unused_win;
    assign unused_win = ^{clk, addr, we, wdata};
    assign rdata      = 8'h00;
  end
endmodule

// File: rtl/memctl_fault_regs.sv
module memctl_fault_regs
  import mcfr_pkg::*;
#(
  parameter int VARIANT    = 0,
  parameter int ADDR_W     = 6,
  parameter int DW         = 32,
  parameter int DIAG_BYTES = 4,
  localparam int IDX_W     = ADDR_W - 2,
  localparam int DG_W      = $clog2(DIAG_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              err_valid,
  input  logic [DW-1:0]     err_status,
  input  logic [DW-1:0]     err_addr0,
  input  logic [DW-1:0]     err_addr1,
  output logic              irq,
  input  logic [DG_W-1:0]   dg_addr,
  input  logic              dg_we,
  input  logic [7:0]        dg_wdata,
  output logic [7:0]        dg_rdata
);
  localparam logic [DW-1:0] CODE  = DW'({4'(VARIANT), 28'h0});
  localparam logic [DW-1:0] WMASK = DW'(en_wmask(VARIANT));
  localparam logic [DW-1:0] KEEP  = DW'(en_keep(VARIANT));

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [NREG-1:0]  we_vec;

  mcfr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr(bus_addr), .we(bus_we), .idx(idx), .in_range(in_range), .we_vec(we_vec)
  );

  logic [DW-1:0] en_q = CODE;
  logic [DW-1:0] dly_q, vid_q, dr_q, ev0_q, ev1_q;
  logic [DW-1:0] fs_q, far0_q, far1_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= en_q & KEEP;
      dly_q <= DW'(DELAY_RST);
      vid_q <= '0;
      dr_q  <= '0;
      ev0_q <= '0;
      ev1_q <= '0;
    end else begin
      if (we_vec[IX_ENABLE]) en_q  <= CODE | (bus_wdata & WMASK);
      if (we_vec[IX_DELAY])  dly_q <= bus_wdata & DW'(DELAY_WMASK);
      if (we_vec[IX_VIDEO])  vid_q <= bus_wdata;
      if (we_vec[IX_DIAG])   dr_q  <= bus_wdata;
      if (we_vec[IX_EVT0])   ev0_q <= bus_wdata;
      if (we_vec[IX_EVT1])   ev1_q <= bus_wdata;
    end
  end

  logic unused_we;
  assign unused_we = we_vec[IX_FADDR0] ^ we_vec[IX_FADDR1];

  mcfr_fault #(.DW(DW)) u_fault (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_status(err_status),
    .err_addr0(err_addr0), .err_addr1(err_addr1), .ce_irq_en(en_q[EN_CEIRQ]),
    .st_we(we_vec[IX_FSTAT]), .wdata(bus_wdata), .status_q(fs_q),
    .far0_q(far0_q), .far1_q(far1_q), .irq_q(irq_q)
  );

  logic [DW-1:0] view [NREG];
  assign view[IX_ENABLE] = en_q;
  assign view[IX_DELAY]  = dly_q;
  assign view[IX_FSTAT]  = fs_q;
  assign view[IX_VIDEO]  = vid_q;
  assign view[IX_FADDR0] = far0_q;
  assign view[IX_FADDR1] = far1_q;
  assign view[IX_DIAG]   = dr_q;
  assign view[IX_EVT0]   = ev0_q;
  assign view[IX_EVT1]   = ev1_q;

  logic [DW-1:0] rd_q;
  always_ff @(posedge clk) begin
    if (rst)           rd_q <= '0;
    else if (in_range) rd_q <= view[idx];
    else               rd_q <= '0;
  end
  assign bus_rdata = rd_q;
  assign irq       = irq_q;

  mcfr_diag #(.PRESENT(VARIANT == 0), .BYTES(DIAG_BYTES)) u_diag (
    .clk(clk), .addr(dg_addr), .we(dg_we), .wdata(dg_wdata), .rdata(dg_rdata)
  );

  assert_variant_code_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(in_range) && $past(idx) == IDX_W'(IX_ENABLE)
    |-> bus_rdata[31:24] == {4'(VARIANT), 4'h0});
  assert_delay_msb_R4: assert property (@(posedge clk) disable iff (rst)
    $past(in_range) && $past(idx) == IDX_W'(IX_DELAY) |-> !bus_rdata[31]);
  assert_oob_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(in_range) |-> bus_rdata == '0);
  assert_far_readonly_R7: assert property (@(posedge clk) disable iff (rst)
    bus_we && !err_valid && (idx == IDX_W'(IX_FADDR0) || idx == IDX_W'(IX_FADDR1))
    |=> $stable(far0_q) && $stable(far1_q));
endmodule

// File: tb/tb_memctl_fault_regs.sv
`timescale 1ns/1ps
module tb_memctl_fault_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rda, rdc;
  logic err_valid = 1'b0;
  logic [31:0] err_status = '0, err_addr0 = '0, err_addr1 = '0;
  logic irqa, irqc;
  logic [1:0] dg_addr = '0;
  logic dg_we = 1'b0;
  logic [7:0] dg_wdata = '0, dga, dgc;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  memctl_fault_regs #(.VARIANT(0)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(rda), .err_valid(err_valid), .err_status(err_status),
    .err_addr0(err_addr0), .err_addr1(err_addr1), .irq(irqa), .dg_addr(dg_addr),
    .dg_we(dg_we), .dg_wdata(dg_wdata), .dg_rdata(dga));
  memctl_fault_regs #(.VARIANT(2)) dut_c (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(rdc), .err_valid(err_valid), .err_status(err_status),
    .err_addr0(err_addr0), .err_addr1(err_addr1), .irq(irqc), .dg_addr(dg_addr),
    .dg_we(dg_we), .dg_wdata(dg_wdata), .dg_rdata(dgc));

  logic [31:0] ma [9];
  logic [31:0] mc [9];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] upd(int v, int idx, logic [31:0] d, logic [31:0] old);
    case (idx)
      0: return {4'(v), 28'h0} | (d & ((v == 0) ? 32'h103 : 32'hBFF));
      1: return d & 32'h7FFF_FFFF;
      2, 3, 6, 7, 8: return d;
      default: return old;
    endcase
  endfunction

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    bus_addr = 6'(idx << 2); bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (idx < 9) begin
      ma[idx] = upd(0, idx, d, ma[idx]);
      mc[idx] = upd(2, idx, d, mc[idx]);
    end
  endtask

  task automatic rd(int idx);
    @(negedge clk);
    bus_addr = 6'(idx << 2) | 6'(idx & 3); bus_we = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic err(logic [31:0] st, logic [31:0] a0, logic [31:0] a1, bit also_clear);
    @(negedge clk);
    err_valid = 1'b1; err_status = st; err_addr0 = a0; err_addr1 = a1;
    if (also_clear) begin bus_addr = 6'd8; bus_we = 1'b1; bus_wdata = 32'h0; end
    @(negedge clk);
    err_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'hA5A5_A5A5;
    pats[3] = 32'h5A5A_5A5A; pats[4] = 32'h1234_5678;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R5 / R6: state after first reset
    for (int i = 0; i < 9; i++) begin
      ma[i] = (i == 1) ? 32'h20 : (i == 4) ? 32'h07C0_0000 : 32'h0;
      mc[i] = ma[i];
    end
    mc[0] = 32'h2000_0000;
    for (int i = 0; i < 9; i++) begin
      rd(i);
      check("R5 R6 reset value A", rda, ma[i]);
      check("R5 R6 reset value C", rdc, mc[i]);
    end
    check("R5 irq low after reset", {31'h0, irqa | irqc}, 32'h0);

    // R1 R2 R3 R4 R7 R11 R12: sweep every index with several patterns
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < 5; p++) begin
        wr(i, pats[p]);
        rd(i);
        check("R1 R3 R4 R7 R11 R12 readback A", rda, (i < 9) ? ma[i] : 32'h0);
        check("R1 R2 R3 R4 R7 R11 R12 readback C", rdc, (i < 9) ? mc[i] : 32'h0);
      end
    end
    for (int i = 0; i < 9; i++) begin
      rd(i);
      check("R12 no side effect A", rda, ma[i]);
      check("R12 no side effect C", rdc, mc[i]);
    end
    wr(7, 32'h1111_1111); wr(8, 32'h2222_2222);
    rd(7); check("R11 event 0 separate", rda, 32'h1111_1111);
    rd(8); check("R11 event 1 separate", rda, 32'h2222_2222);

    // R6: enable retention across reset
    wr(0, 32'hFFFF_FFFF);
    do_reset();
    rd(0);
    check("R6 retained A", rda, 32'h0000_0100);
    check("R6 retained C", rdc, 32'h2000_0BFC);
    rd(1); check("R5 delay after reset", rda, 32'h20);
    rd(4); check("R5 faddr0 after reset", rdc, 32'h07C0_0000);
    rd(8); check("R5 event 1 after reset", rda, 32'h0);

    // R8 R9 R10: error capture
    wr(0, 32'h0);
    err(32'h0000_1201, 32'hDEAD_0001, 32'h00BE_EF00, 0);
    check("R9 correctable masked", {31'h0, irqa}, 32'h0);
    rd(2); check("R8 status load", rda, 32'h0000_1201);
    rd(4); check("R8 faddr0 load", rdc, 32'hDEAD_0001);
    rd(5); check("R8 faddr1 load", rda, 32'h00BE_EF00);
    err(32'h0000_0008, 32'h1, 32'h2, 0);
    check("R9 uncorrectable raises", {31'h0, irqa}, 32'h1);
    rd(2); check("R8 multiple flag", rda, 32'h0001_0008);
    wr(2, 32'h0);
    check("R10 write clears irq", {31'h0, irqa | irqc}, 32'h0);
    rd(2); check("R10 status stored", rdc, 32'h0);
    wr(0, 32'h2);
    err(32'h0000_0001, 32'h3, 32'h4, 0);
    check("R9 correctable enabled", {31'h0, irqc}, 32'h1);
    rd(2); check("R8 no multiple when clear", rda, 32'h1);
    err(32'h0000_0008, 32'h5, 32'h6, 1);
    check("R9 report beats write irq", {31'h0, irqa}, 32'h1);
    rd(2); check("R9 report beats write status", rda, 32'h0001_0008);
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    rd(4); check("R7 faddr0 ignored", rda, 32'h5);
    rd(5); check("R7 faddr1 ignored", rdc, 32'h6);
    check("R7 irq kept", {31'h0, irqa}, 32'h1);

    // R13: diagnostic window
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); dg_addr = 2'(b); dg_we = 1'b1; dg_wdata = 8'(8'h3C ^ (b * 8'h11));
    end
    @(negedge clk); dg_we = 1'b0;
    for (int b = 3; b >= 0; b--) begin
      @(negedge clk); dg_addr = 2'(b);
      @(posedge clk); #1;
      check("R13 window byte A", {24'h0, dga}, {24'h0, 8'(8'h3C ^ (b * 8'h11))});
      check("R13 window absent C", {24'h0, dgc}, 32'h0);
    end
    finish_run();
  end
endmodule